// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block executes the configuration step that comes before a run of vector instructions. Each request carries three things. The first is an application length, taken from a scalar source register. The second is a 2-bit element-width code. The third is a 2-bit register-group multiplier code. From the two codes the block works out how many elements one register group can hold. It grants the requested length or that capacity, whichever is smaller.

The granted length, the element width and the group size are held in control registers. These registers drive the vector execution logic. The granted length is also returned on a write-back port for the scalar destination register.

Software strip-mines a loop by asking for the remaining count on each pass. It then subtracts the grant from that count. Register grouping multiplies the capacity of each instruction. An encoding that the unit cannot support raises an illegal-type flag and zeroes the length.

Top module: `vcfg_unit`

## Requirements
- R1: After synchronous reset, and before any request, the outputs read as follows: `cur_vl` = 0, `cur_sew` = 2'b00, `cur_lmul` = 2'b00, `cur_vill` = 0 and `wb_valid` = 0.
- R2: On the clock edge where `cfg_valid` is high and the request is legal, `cur_vl` becomes min(`cfg_avl`, VLMAX). Here VLMAX = (2^lmul_code × VLEN) / (8 × 2^sew_code), with VLEN = 128 by default.
- R3: `wb_valid` is high for exactly the cycle after each cycle in which `cfg_valid` is high. While it is high, `wb_len` equals the newly granted length, zero-extended to XLEN.
- R4: A request at or above VLMAX is granted VLMAX. For example, sew_code 2'b10 (32 bits) grants 4 with lmul_code 2'b00, and grants 32 with lmul_code 2'b11. A request of 32'hFFFF_FFFF is also granted VLMAX.
- R5: A request below VLMAX is granted unchanged, and a request of 0 is granted 0. For example, with 32-bit elements and a multiplier of 1, a request of 7 is granted 4 and the following request of 3 is granted 3.
- R6: On a legal request, `cur_sew` and `cur_lmul` take the requested codes. Element-width codes are 00 for 8, 01 for 16, 10 for 32 and 11 for 64 bits. Multiplier codes are 00 for 1, 01 for 2, 10 for 4 and 11 for 8.
- R7: A request is illegal when its element width is wider than ELEN (default 32, so code 2'b11 is illegal) or its multiplier code is above MAX_LMUL_CODE. An illegal request sets `cur_vill` = 1, `cur_vl` = 0, `cur_sew` = 2'b00 and `cur_lmul` = 2'b00, and it writes back 0.
- R8: In a cycle with `cfg_valid` low, `cur_vl`, `cur_sew`, `cur_lmul` and `cur_vill` keep their values and `wb_valid` is 0.
- R9: A legal request that follows an illegal one clears `cur_vill`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | A configuration request is present this cycle |
| cfg_avl | input | XLEN | Requested application length |
| cfg_sew | input | 2 | Element-width code |
| cfg_lmul | input | 2 | Group multiplier code |
| wb_valid | output | 1 | Write-back of the granted length is valid |
| wb_len | output | XLEN | Granted length for the scalar destination |
| cur_sew | output | 2 | Current element-width code |
| cur_lmul | output | 2 | Current group multiplier code |
| cur_vl | output | VL_W | Current vector length |
| cur_vill | output | 1 | Current type is illegal |

## Verification
The assertions assume that `cfg_avl`, `cfg_sew` and `cfg_lmul` are stable while `cfg_valid` is high. They also assume that a request may arrive in any cycle, including back-to-back cycles, and that nothing arrives during reset. The stimulus changes inputs only just after a rising edge, and it releases reset before the first request. It mixes directed strip-mining and boundary requests with back-to-back random requests over every code pair. The random lengths cover zero, values near each VLMAX and the all-ones word.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  typedef logic [1:0] sew_code_t;
  typedef logic [1:0] lmul_code_t;

  typedef struct packed {
    logic       vill;
    lmul_code_t lmul;
    sew_code_t  sew;
  } vtype_t;

  localparam int unsigned NUM_CODES = 4;
  localparam int unsigned MIN_SEW   = 8;

  function automatic vtype_t vtype_reset();
    vtype_t t;
    t.vill = 1'b0;
    t.lmul = 2'b00;
    t.sew  = 2'b00;
    return t;
  endfunction

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
#(
  parameter int unsigned ELEN          = 32,
  parameter int unsigned MAX_LMUL_CODE = 3
) (
  input  sew_code_t  sew,
  input  lmul_code_t lmul,
  output logic       legal
);

  logic [NUM_CODES-1:0] sew_ok;
  logic [NUM_CODES-1:0] lmul_ok;

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_codes
    localparam int unsigned WIDTH = MIN_SEW << c;
    assign sew_ok[c]  = (WIDTH <= ELEN);
    assign lmul_ok[c] = (c <= MAX_LMUL_CODE);
  end

  always_comb begin
    legal = sew_ok[sew] & lmul_ok[lmul];
  end

endmodule

// File: rtl/vcfg_limit.sv
module vcfg_limit
  import vcfg_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned VL_W = 8
) (
  input  sew_code_t       sew,
  input  lmul_code_t      lmul,
  output logic [VL_W-1:0] vlmax
);

  localparam int unsigned BITS_W = $clog2(VLEN) + 4;

  logic [BITS_W-1:0] group_bits;
  logic [BITS_W-1:0] elems;

  always_comb begin
    group_bits = BITS_W'(VLEN) << lmul;
    elems      = group_bits >> (3 + sew);
    vlmax      = elems[VL_W-1:0];
  end

endmodule

// File: rtl/vcfg_grant.sv
module vcfg_grant #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VL_W = 8
) (
  input  logic [XLEN-1:0] avl,
  input  logic [VL_W-1:0] vlmax,
  input  logic            legal,
  output logic [VL_W-1:0] grant
);

  logic [XLEN-1:0] cap;
  logic            below;

  always_comb begin
    cap   = XLEN'(vlmax);
    below = (avl < cap);
    if (!legal)
      grant = '0;
    else if (below)
      grant = avl[VL_W-1:0];
    else
      grant = vlmax;
  end

endmodule

// File: rtl/vcfg_state.sv
module vcfg_state
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VL_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  logic            legal,
  input  sew_code_t       sew,
  input  lmul_code_t      lmul,
  input  logic [VL_W-1:0] grant,
  output vtype_t          vtype_q,
  output logic [VL_W-1:0] vl_q,
  output logic            wb_valid_q,
  output logic [XLEN-1:0] wb_len_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vtype_q    <= vtype_reset();
      vl_q       <= '0;
      wb_valid_q <= 1'b0;
      wb_len_q   <= '0;
    end else begin
      wb_valid_q <= upd;
      if (upd) begin
        vl_q     <= grant;
        wb_len_q <= XLEN'(grant);
        if (legal) begin
          vtype_q.vill <= 1'b0;
          vtype_q.sew  <= sew;
          vtype_q.lmul <= lmul;
        end else begin
          vtype_q <= vtype_reset();
          vtype_q.vill <= 1'b1;
        end
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(vtype_q) && $stable(vl_q) && !wb_valid_q));

  assert_wb_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    upd |=> (wb_valid_q && wb_len_q == XLEN'(vl_q)));

  assert_vill_zero_R7: assert property (@(posedge clk) disable iff (rst)
    vtype_q.vill |-> (vl_q == '0 && vtype_q.sew == 2'b00 && vtype_q.lmul == 2'b00));

  assert_clear_vill_R9: assert property (@(posedge clk) disable iff (rst)
    (upd && legal) |=> !vtype_q.vill);

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN          = 32,
  parameter int unsigned VLEN          = 128,
  parameter int unsigned ELEN          = 32,
  parameter int unsigned MAX_LMUL_CODE = 3,
  localparam int unsigned VL_W         = $clog2(VLEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_valid,
  input  logic [XLEN-1:0] cfg_avl,
  input  logic [1:0]      cfg_sew,
  input  logic [1:0]      cfg_lmul,
  output logic            wb_valid,
  output logic [XLEN-1:0] wb_len,
  output logic [1:0]      cur_sew,
  output logic [1:0]      cur_lmul,
  output logic [VL_W-1:0] cur_vl,
  output logic            cur_vill
);

  logic            legal;
  logic [VL_W-1:0] vlmax;
  logic [VL_W-1:0] grant;
  vtype_t          vtype_q;

  vcfg_decode #(.ELEN(ELEN), .MAX_LMUL_CODE(MAX_LMUL_CODE)) u_decode (
    .sew   (cfg_sew),
    .lmul  (cfg_lmul),
    .legal (legal)
  );

  vcfg_limit #(.VLEN(VLEN), .VL_W(VL_W)) u_limit (
    .sew   (cfg_sew),
    .lmul  (cfg_lmul),
    .vlmax (vlmax)
  );

  vcfg_grant #(.XLEN(XLEN), .VL_W(VL_W)) u_grant (
    .avl   (cfg_avl),
    .vlmax (vlmax),
    .legal (legal),
    .grant (grant)
  );

  vcfg_state #(.XLEN(XLEN), .VL_W(VL_W)) u_state (
    .clk        (clk),
    .rst        (rst),
    .upd        (cfg_valid),
    .legal      (legal),
    .sew        (cfg_sew),
    .lmul       (cfg_lmul),
    .grant      (grant),
    .vtype_q    (vtype_q),
    .vl_q       (cur_vl),
    .wb_valid_q (wb_valid),
    .wb_len_q   (wb_len)
  );

  assign cur_sew  = vtype_q.sew;
  assign cur_lmul = vtype_q.lmul;
  assign cur_vill = vtype_q.vill;

  assert_vl_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && legal) |=> (cur_vl <= $past(vlmax) &&
                              XLEN'(cur_vl) <= $past(cfg_avl)));

  assert_vl_cap_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && legal && cfg_avl >= XLEN'(vlmax)) |=> (cur_vl == $past(vlmax)));

  assert_codes_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && legal) |=> (cur_sew == $past(cfg_sew) && cur_lmul == $past(cfg_lmul)));

  assert_illegal_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !legal) |=> (cur_vill && cur_vl == '0 && wb_len == '0));

endmodule

// File: tb/vcfg_unit_test.sv
`timescale 1ns/1ps
module vcfg_unit_test;

  localparam int XLEN = 32;
  localparam int VL_W = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_valid = 1'b0;
  logic [XLEN-1:0] cfg_avl = '0;
  logic [1:0]      cfg_sew = 2'b00;
  logic [1:0]      cfg_lmul = 2'b00;
  logic            wb_valid;
  logic [XLEN-1:0] wb_len;
  logic [1:0]      cur_sew;
  logic [1:0]      cur_lmul;
  logic [VL_W-1:0] cur_vl;
  logic            cur_vill;

  int checks = 0;
  int errors = 0;

  longint m_vl = 0;
  int     m_sew = 0, m_lmul = 0, m_vill = 0, m_wbv = 0;
  longint m_wbl = 0;
  bit     model_on = 0;

  always #5 clk = ~clk;

  vcfg_unit uut (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_avl(cfg_avl),
    .cfg_sew(cfg_sew), .cfg_lmul(cfg_lmul), .wb_valid(wb_valid),
    .wb_len(wb_len), .cur_sew(cur_sew), .cur_lmul(cur_lmul),
    .cur_vl(cur_vl), .cur_vill(cur_vill)
  );

  function automatic longint cap_of(int s, int l);
    return (128 * (1 << l)) / (8 * (1 << s));
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    if (rst) begin
      m_vl = 0; m_sew = 0; m_lmul = 0; m_vill = 0; m_wbv = 0; m_wbl = 0;
    end else begin
      m_wbv = cfg_valid;
      if (cfg_valid) begin
        if ((8 << cfg_sew) > 32) begin
          m_vill = 1; m_vl = 0; m_sew = 0; m_lmul = 0;
        end else begin
          longint c;
          c = cap_of(cfg_sew, cfg_lmul);
          m_vill = 0; m_sew = cfg_sew; m_lmul = cfg_lmul;
          m_vl = (longint'(cfg_avl) < c) ? longint'(cfg_avl) : c;
        end
        m_wbl = m_vl;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check(m_vill ? "R7 vl" : "R2 vl", cur_vl, m_vl);
      check("R6 sew", cur_sew, m_sew);
      check("R6 lmul", cur_lmul, m_lmul);
      check("R7 vill", cur_vill, m_vill);
      check(m_wbv ? "R3 wb_valid" : "R8 wb_valid", wb_valid, m_wbv);
      if (m_wbv) check("R3 wb_len", wb_len, m_wbl);
    end
  end

  task automatic cfg(longint avl, int s, int l);
    @(posedge clk); #1;
    cfg_valid = 1'b1; cfg_avl = avl[XLEN-1:0];
    cfg_sew = s[1:0]; cfg_lmul = l[1:0];
    @(posedge clk); #1;
    cfg_valid = 1'b0;
    #3;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 vl", cur_vl, 0);
    check("R1 sew", cur_sew, 0);
    check("R1 lmul", cur_lmul, 0);
    check("R1 vill", cur_vill, 0);
    check("R1 wb_valid", wb_valid, 0);
    model_on = 1;

    // R5 strip-mining
    cfg(7, 2, 0);
    check("R5 first pass", cur_vl, 4);
    check("R3 wb first", wb_len, 4);
    cfg(3, 2, 0);
    check("R5 remainder", cur_vl, 3);
    cfg(0, 1, 2);
    check("R5 zero", cur_vl, 0);
    // R4 caps
    cfg(1024, 2, 3);
    check("R4 lmul8 sew32", cur_vl, 32);
    cfg(64'hFFFF_FFFF, 0, 3);
    check("R4 all ones", cur_vl, 128);
    cfg(4, 2, 0);
    check("R4 exact cap", cur_vl, 4);
    check("R6 sew code", cur_sew, 2);
    // R8 idle hold
    repeat (4) @(posedge clk);
    #4;
    check("R8 hold vl", cur_vl, 4);
    check("R8 no wb", wb_valid, 0);
    // R7 illegal, R9 recovery
    cfg(20, 3, 1);
    check("R7 vill set", cur_vill, 1);
    check("R7 vl zero", cur_vl, 0);
    check("R7 wb zero", wb_len, 0);
    cfg(20, 1, 1);
    check("R9 vill cleared", cur_vill, 0);
    check("R9 vl", cur_vl, 16);

    // back-to-back random stream, checked by the model
    @(posedge clk); #1;
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      cfg_valid = ($urandom_range(0, 3) != 0);
      cfg_sew   = 2'($urandom_range(0, 3));
      cfg_lmul  = 2'($urandom_range(0, 3));
      if (r == 0) cfg_avl = 32'hFFFF_FFFF;
      else if (r == 1) cfg_avl = 32'(cap_of(cfg_sew, cfg_lmul));
      else cfg_avl = 32'($urandom_range(0, 140));
      @(posedge clk); #1;
    end
    cfg_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule